// File: doc/BRIEF.md
# Timer Output-Compare Unit

This block hangs off a free-running time counter and provides a set of output-compare channels (four by default). Each channel holds an active compare value. When the counter lands on that value, the channel raises a sticky status flag. It can also raise an interrupt request and change its output pin. The pin either toggles or emits a single-cycle high pulse. The pulse form suits a once-per-second timing mark.

Software programs a channel through a small register window and a combinational read port. First it clears the mode and writes the first target, which goes straight into the active slot. Then it selects a mode and writes the following target, which waits in a pending slot. On each match the pending value is promoted to active, so software only needs to refill the pending slot after each event. A summary register collects the flags of all channels.

Top module: `tcmp_unit`

## Requirements
- R1: After reset all flags, pins and interrupt requests are 0, and every control and compare register reads 0.
- R2: Channel n has its control register at byte address 8n and its compare register at 8n+4. Reading the compare address returns the active compare value. The summary register at address 8·NUM_CH holds the flag of channel n in bit n. It is read-only, and writes to it change nothing.
- R3: The control register holds the mode in bits [5:2], the interrupt enable in bit 6 and the flag in bit 7. Mode code 0x0 turns the channel off, 0x5 selects toggle and 0xF selects pulse.
- R4: A channel matches in a cycle when its mode is nonzero, the counter equals its active value, and either the counter differs from its value in the previous cycle or the wrap input is high. The flag is set at that clock edge. A channel whose mode is 0 never matches.
- R5: In toggle mode the pin inverts at the edge of each match and otherwise holds.
- R6: In pulse mode the pin is high for exactly the one cycle that follows a match.
- R7: Writing the control register with bit 7 set clears the flag. Writing bit 7 as 0 leaves the flag as it was. A match in the same cycle takes priority over a clear.
- R8: A channel's interrupt output is high exactly while both its flag and its interrupt enable are set.
- R9: A compare write while the mode is 0 loads the active value directly and discards any pending value.
- R10: A compare write while the mode is nonzero only queues a pending value. On the next match the pending value becomes active. With nothing pending, the active value stays and matches again when the counter returns to it.
- R11: A compare value of 0 matches when the counter wraps to 0 with the wrap input high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| count_i | input | CNT_W | Current time-counter value |
| wrap_i | input | 1 | Pulse marking that the counter has just wrapped |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Byte address of the write |
| wr_data_i | input | DATA_W | Write data |
| rd_addr_i | input | ADDR_W | Byte address of the read |
| rd_data_o | output | DATA_W | Read data, combinational from rd_addr_i |
| pin_o | output | NUM_CH | Channel output pins |
| irq_o | output | NUM_CH | Per-channel interrupt requests |
| flag_sum_o | output | NUM_CH | Flags of all channels |

## Verification
A counter value driven before a clock edge produces its flag and pin result at that same edge. The interrupt output follows the flag within the same cycle. The bench therefore drives the counter one falling edge ahead and checks pin, flag and interrupt at the next falling edge. A register write takes effect at the edge that samples the strobe. Because the read path is combinational, each readback is taken 1 ns after setting the read address, well before the next rising edge. Pulse length and toggle polarity are checked on the cycles directly after a match, and again after further counter steps that must not fire.

// File: rtl/tcmp_pkg.sv
package tcmp_pkg;
  localparam int MODE_W     = 4;
  localparam int MODE_LSB   = 2;
  localparam int IE_BIT     = 6;
  localparam int FLAG_BIT   = 7;
  localparam int STRIDE_LSB = 3;  // 8-byte register pair per channel
  localparam int SUB_BIT    = 2;  // selects compare word inside the pair

  typedef logic [MODE_W-1:0] mode_t;

  localparam mode_t MODE_OFF    = 4'h0;
  localparam mode_t MODE_TOGGLE = 4'h5;
  localparam mode_t MODE_PULSE  = 4'hF;
endpackage

// File: rtl/tcmp_tick.sv
module tcmp_tick #(
  parameter int CNT_W = 31
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] count_i,
  input  logic             wrap_i,
  output logic             tick_o
);
  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) count_q <= '0;
    else         count_q <= count_i;
  end

  // a fresh counter value, or a wrap back onto the same value
  assign tick_o = wrap_i || (count_i != count_q);
endmodule

// File: rtl/tcmp_regdec.sv
module tcmp_regdec
  import tcmp_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic                           wr_en_i,
  input  logic [ADDR_W-1:0]              wr_addr_i,
  input  logic [ADDR_W-1:0]              rd_addr_i,
  input  logic [NUM_CH-1:0][DATA_W-1:0]  ctrl_rd_i,
  input  logic [NUM_CH-1:0][DATA_W-1:0]  cmp_rd_i,
  input  logic [NUM_CH-1:0]              status_i,
  output logic [NUM_CH-1:0]              ctrl_we_o,
  output logic [NUM_CH-1:0]              cmp_we_o,
  output logic [DATA_W-1:0]              rd_data_o
);
  localparam int IDX_W = ADDR_W - STRIDE_LSB;

  logic [IDX_W-1:0] wr_idx, rd_idx;
  logic             wr_sub, rd_sub;
  logic             unused_addr_bits;

  assign wr_idx = wr_addr_i[ADDR_W-1:STRIDE_LSB];
  assign rd_idx = rd_addr_i[ADDR_W-1:STRIDE_LSB];
  assign wr_sub = wr_addr_i[SUB_BIT];
  assign rd_sub = rd_addr_i[SUB_BIT];
  assign unused_addr_bits = ^{wr_addr_i[SUB_BIT-1:0], rd_addr_i[SUB_BIT-1:0]};

  for (genvar i = 0; i < NUM_CH; i++) begin : g_dec
    assign ctrl_we_o[i] = wr_en_i && !wr_sub && (wr_idx == IDX_W'(i));
    assign cmp_we_o[i]  = wr_en_i &&  wr_sub && (wr_idx == IDX_W'(i));
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (rd_idx == IDX_W'(i)) rd_data_o = rd_sub ? cmp_rd_i[i] : ctrl_rd_i[i];
    end
    if (rd_idx == IDX_W'(NUM_CH) && !rd_sub) rd_data_o = DATA_W'(status_i);
  end
endmodule

// File: rtl/tcmp_channel.sv
module tcmp_channel
  import tcmp_pkg::*;
#(
  parameter int CNT_W  = 31,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              tick_i,
  input  logic              ctrl_we_i,
  input  logic              cmp_we_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] ctrl_rd_o,
  output logic [DATA_W-1:0] cmp_rd_o,
  output logic              pin_o,
  output logic              irq_o,
  output logic              flag_o,
  output logic              match_o,
  output logic              clr_o,
  output logic              ie_o,
  output mode_t             mode_o
);
  mode_t            mode_q;
  logic             ie_q, flag_q, pin_q, pend_vld_q;
  logic [CNT_W-1:0] act_q, pend_q;
  logic             match, clr;

  assign match = (mode_q != MODE_OFF) && tick_i && (count_i == act_q);
  assign clr   = ctrl_we_i && wr_data_i[FLAG_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q     <= MODE_OFF;
      ie_q       <= 1'b0;
      flag_q     <= 1'b0;
      pin_q      <= 1'b0;
      act_q      <= '0;
      pend_q     <= '0;
      pend_vld_q <= 1'b0;
    end else begin
      if (ctrl_we_i) begin
        mode_q <= wr_data_i[MODE_LSB +: MODE_W];
        ie_q   <= wr_data_i[IE_BIT];
      end

      if (match)    flag_q <= 1'b1;
      else if (clr) flag_q <= 1'b0;

      if (match && pend_vld_q) begin
        act_q      <= pend_q;
        pend_vld_q <= 1'b0;
      end
      // a write in the same cycle lands after the promotion
      if (cmp_we_i) begin
        if (mode_q == MODE_OFF) begin
          act_q      <= wr_data_i[CNT_W-1:0];
          pend_vld_q <= 1'b0;
        end else begin
          pend_q     <= wr_data_i[CNT_W-1:0];
          pend_vld_q <= 1'b1;
        end
      end

      case (mode_q)
        MODE_TOGGLE: if (match) pin_q <= ~pin_q;
        MODE_PULSE:  pin_q <= match;
        default:     pin_q <= pin_q;
      endcase
    end
  end

  always_comb begin
    ctrl_rd_o                       = '0;
    ctrl_rd_o[MODE_LSB +: MODE_W]   = mode_q;
    ctrl_rd_o[IE_BIT]               = ie_q;
    ctrl_rd_o[FLAG_BIT]             = flag_q;
  end

  assign cmp_rd_o = DATA_W'(act_q);
  assign pin_o    = pin_q;
  assign irq_o    = flag_q && ie_q;
  assign flag_o   = flag_q;
  assign match_o  = match;
  assign clr_o    = clr;
  assign ie_o     = ie_q;
  assign mode_o   = mode_q;
endmodule

// File: rtl/tcmp_unit.sv
module tcmp_unit
  import tcmp_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 31,
  parameter int DATA_W = 32,
  parameter int ADDR_W = $clog2(NUM_CH + 1) + STRIDE_LSB
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              wrap_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [NUM_CH-1:0] pin_o,
  output logic [NUM_CH-1:0] irq_o,
  output logic [NUM_CH-1:0] flag_sum_o
);
  logic                          tick;
  logic [NUM_CH-1:0]             ctrl_we, cmp_we;
  logic [NUM_CH-1:0][DATA_W-1:0] ctrl_rd, cmp_rd;
  logic [NUM_CH-1:0]             match_w, clr_w, ie_w;
  mode_t [NUM_CH-1:0]            mode_w;

  tcmp_tick #(.CNT_W(CNT_W)) i_tick (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .count_i (count_i),
    .wrap_i  (wrap_i),
    .tick_o  (tick)
  );

  tcmp_regdec #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_regdec (
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .rd_addr_i (rd_addr_i),
    .ctrl_rd_i (ctrl_rd),
    .cmp_rd_i  (cmp_rd),
    .status_i  (flag_sum_o),
    .ctrl_we_o (ctrl_we),
    .cmp_we_o  (cmp_we),
    .rd_data_o (rd_data_o)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    tcmp_channel #(.CNT_W(CNT_W), .DATA_W(DATA_W)) i_ch (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .count_i   (count_i),
      .tick_i    (tick),
      .ctrl_we_i (ctrl_we[i]),
      .cmp_we_i  (cmp_we[i]),
      .wr_data_i (wr_data_i),
      .ctrl_rd_o (ctrl_rd[i]),
      .cmp_rd_o  (cmp_rd[i]),
      .pin_o     (pin_o[i]),
      .irq_o     (irq_o[i]),
      .flag_o    (flag_sum_o[i]),
      .match_o   (match_w[i]),
      .clr_o     (clr_w[i]),
      .ie_o      (ie_w[i]),
      .mode_o    (mode_w[i])
    );
  end
endmodule

// File: rtl/tcmp_unit_chk.sv
module tcmp_unit_chk
  import tcmp_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_CH-1:0]  flag_i,
  input logic [NUM_CH-1:0]  ie_i,
  input logic [NUM_CH-1:0]  irq_i,
  input logic [NUM_CH-1:0]  match_i,
  input logic [NUM_CH-1:0]  clr_i,
  input logic [NUM_CH-1:0]  pin_i,
  input mode_t [NUM_CH-1:0] mode_i
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    // R8
    irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_i[i] |-> (flag_i[i] && ie_i[i]));

    // R4
    flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      match_i[i] |=> flag_i[i]);

    // R7
    flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_i[i] && !clr_i[i]) |=> flag_i[i]);

    // R6
    pulse_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i[i] == MODE_PULSE && !match_i[i]) |=> !pin_i[i]);

    // R5
    toggle_flip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i[i] == MODE_TOGGLE && match_i[i]) |=> (pin_i[i] != $past(pin_i[i])));

    // R4
    off_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i[i] == MODE_OFF) |-> !match_i[i]);
  end
endmodule

bind tcmp_unit tcmp_unit_chk #(.NUM_CH(NUM_CH)) i_tcmp_unit_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .flag_i  (flag_sum_o),
  .ie_i    (ie_w),
  .irq_i   (irq_o),
  .match_i (match_w),
  .clr_i   (clr_w),
  .pin_i   (pin_o),
  .mode_i  (mode_w)
);

// File: tb/test_tcmp_unit.sv
`timescale 1ns/1ps
module test_tcmp_unit;
  localparam int NUM_CH = 4;
  localparam int CNT_W  = 31;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 6;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [CNT_W-1:0]  cnt = '0;
  logic              wrap = 1'b0;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic [DATA_W-1:0] rd_data;
  logic [NUM_CH-1:0] pin, irq, flags;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  tcmp_unit #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_tcmp_unit (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .count_i    (cnt),
    .wrap_i     (wrap),
    .wr_en_i    (wr_en),
    .wr_addr_i  (wr_addr),
    .wr_data_i  (wr_data),
    .rd_addr_i  (rd_addr),
    .rd_data_o  (rd_data),
    .pin_o      (pin),
    .irq_o      (irq),
    .flag_sum_o (flags)
  );

  // channel 0, pulse mode, active 10, pending 20, interrupt enabled
  typedef struct packed {
    logic [CNT_W-1:0] cnt;
    logic             exp_pin;
    logic             exp_flag;
    logic             exp_irq;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VECS [NVEC] = '{
    '{31'd8,  1'b0, 1'b0, 1'b0},
    '{31'd9,  1'b0, 1'b0, 1'b0},
    '{31'd10, 1'b1, 1'b1, 1'b1},
    '{31'd11, 1'b0, 1'b1, 1'b1},
    '{31'd11, 1'b0, 1'b1, 1'b1},
    '{31'd10, 1'b0, 1'b1, 1'b1},
    '{31'd12, 1'b0, 1'b1, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [ADDR_W-1:0] a, input logic [31:0] exp);
    rd_addr = a;
    #1;
    check(req, rd_data, exp);
  endtask

  task automatic step(input logic [CNT_W-1:0] c, input logic w);
    cnt = c; wrap = w;
    @(negedge clk);
    wrap = 1'b0;
  endtask

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 flags", 32'(flags), 32'h0);
    check("R1 pins", 32'(pin), 32'h0);
    check("R1 irq", 32'(irq), 32'h0);
    rd_chk("R1 ctrl0", 6'h00, 32'h0);
    rd_chk("R1 cmp0", 6'h04, 32'h0);

    // R9 first value loads active while mode is 0; R10 second value queues
    wr(6'h00, 32'h0);
    wr(6'h04, 32'd10);
    wr(6'h00, 32'h7C);
    wr(6'h04, 32'd20);
    rd_chk("R10 cmp0 still active", 6'h04, 32'd10);
    rd_chk("R3 ctrl0 fields", 6'h00, 32'h7C);

    // vector walk: R4 R6 R8
    for (int k = 0; k < NVEC; k++) begin
      step(VECS[k].cnt, 1'b0);
      check("R6 pin0", 32'(pin[0]), 32'(VECS[k].exp_pin));
      check("R4 flag0", 32'(flags[0]), 32'(VECS[k].exp_flag));
      check("R8 irq0", 32'(irq[0]), 32'(VECS[k].exp_irq));
    end
    rd_chk("R10 pending promoted", 6'h04, 32'd20);
    rd_chk("R3 ctrl0 flag bit", 6'h00, 32'hFC);

    // R7 write-one-to-clear
    wr(6'h00, 32'h7C);
    check("R7 zero keeps flag", 32'(flags[0]), 32'h1);
    wr(6'h00, 32'hFC);
    check("R7 one clears flag", 32'(flags[0]), 32'h0);
    check("R8 irq follows clear", 32'(irq[0]), 32'h0);
    rd_chk("R7 ctrl0 after clear", 6'h00, 32'h7C);

    // R8 enable off: flag without interrupt
    wr(6'h00, 32'h3C);
    wr(6'h04, 32'd30);
    rd_chk("R10 queued not active", 6'h04, 32'd20);
    step(31'd20, 1'b0);
    check("R6 pin0 at 20", 32'(pin[0]), 32'h1);
    check("R4 flag0 at 20", 32'(flags[0]), 32'h1);
    check("R8 irq masked", 32'(irq[0]), 32'h0);
    rd_chk("R10 30 now active", 6'h04, 32'd30);

    // R5 toggle, channel 1, reuse of active value across wrap
    wr(6'h08, 32'h0);
    wr(6'h0C, 32'd5);
    wr(6'h08, 32'h14);
    step(31'd5, 1'b0);
    check("R5 toggle high", 32'(pin[1]), 32'h1);
    check("R2 flag1", 32'(flags[1]), 32'h1);
    step(31'd6, 1'b0);
    check("R5 holds", 32'(pin[1]), 32'h1);
    step(31'd0, 1'b1);
    check("R5 holds over wrap", 32'(pin[1]), 32'h1);
    step(31'd5, 1'b0);
    check("R10 active reused, R5 toggle low", 32'(pin[1]), 32'h0);

    // R11 zero through wrap, channel 2 pulse
    wr(6'h14, 32'h0);
    wr(6'h10, 32'h3C);
    step(31'h7FFF_FFFF, 1'b0);
    check("R11 before wrap", 32'(pin[2]), 32'h0);
    step(31'd0, 1'b1);
    check("R11 pin2 at zero", 32'(pin[2]), 32'h1);
    check("R11 flag2", 32'(flags[2]), 32'h1);
    step(31'd1, 1'b0);
    check("R6 pin2 one cycle", 32'(pin[2]), 32'h0);

    // R4 mode 0 never matches, channel 3
    wr(6'h1C, 32'd7);
    rd_chk("R9 cmp3 direct", 6'h1C, 32'd7);
    step(31'd7, 1'b0);
    check("R4 off no flag", 32'(flags[3]), 32'h0);
    check("R4 off no pin", 32'(pin[3]), 32'h0);

    // R2 summary register, read-only
    rd_chk("R2 summary", 6'h20, 32'h7);
    wr(6'h20, 32'hFF);
    rd_chk("R2 summary ignores write", 6'h20, 32'h7);
    check("R2 flags port", 32'(flags), 32'h7);

    // R9 mode clear discards pending
    wr(6'h0C, 32'd40);
    rd_chk("R10 queue on ch1", 6'h0C, 32'd5);
    wr(6'h08, 32'h80);
    check("R7 ch1 cleared", 32'(flags[1]), 32'h0);
    wr(6'h0C, 32'd9);
    rd_chk("R9 direct load", 6'h0C, 32'd9);
    wr(6'h08, 32'h14);
    step(31'd9, 1'b0);
    check("R5 toggle at 9", 32'(pin[1]), 32'h1);
    step(31'd40, 1'b0);
    check("R9 pending discarded", 32'(pin[1]), 32'h1);
    rd_chk("R9 active kept", 6'h0C, 32'd9);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule